// File: doc/BRIEF.md
# Cascading Multi-Level Reset Controller

This block decides which parts of a chip are held in reset and for how long. It knows five reset levels. From strongest to weakest they are power-on, brownout, boot, system and CPU-only. Any trigger that starts one level also holds every weaker level. Release then steps down one level at a time until the chip reaches its run state. Each level has a minimum hold time in clock cycles. The boot level also waits for an external boot routine to report that it has finished.

The trigger sources are:
- a supply-good flag, which acts as the asynchronous power-on input;
- a brownout flag, which can be set up to raise an interrupt instead of a reset;
- a shutdown-exit event;
- a fatal clock fault;
- a watchdog expiry;
- boot-loader entry or exit;
- debug requests;
- a software request that carries a level code;
- the external active-low reset pin.

The pin is timed in slow-clock ticks. A short press causes a boot-level reset when the pin is released. A press that reaches the long threshold causes a power-on-level reset at once, without waiting for release. Five domain reset outputs are driven by the controller: shutdown-retention memory, power/core, RTC, peripherals and CPU. It also drives a run indicator and a latched cause code.

Top module: `rst_cascade_ctrl`

## Requirements
- R1: Domain resets are always nested. Shutdown memory implies power/core, which implies RTC, which implies peripherals, which implies CPU. `run_o` is high only when no domain reset is asserted.
- R2: While `por_n_i` is low, every domain reset is asserted without waiting for a clock edge, `run_o` is low and `cause_o` is 5. After `por_n_i` returns high, the sequence steps through power-on, brownout, boot and system levels before reaching run.
- R3: Each level reached in a sequence is held for at least `HOLD_CYC` clock cycles. Brownout, system and CPU-only levels are held for exactly that many cycles, then release to the next lower level.
- R4: When the boot level's hold time ends, `boot_start_o` is a single-cycle pulse. The RTC reset does not release until `boot_done_i` has been seen. After that, the system level is held for `HOLD_CYC` cycles and the chip enters run.
- R5: A watchdog expiry, a boot-loader event or a debug system request asserts only the peripheral and CPU resets. The RTC, power/core and shutdown-memory resets stay low.
- R6: A CPU-only request asserts only `cpu_rst_o`, for `HOLD_CYC` cycles. The request comes from software code 1 or from a debug request with `dbg_cpu_only_i` high.
- R7: Software level codes are 5 = power-on, 3 = boot, 2 = system and 1 = CPU-only. Codes 0, 4, 6 and 7 are ignored, and `run_o` stays high.
- R8: With `bor_as_irq_i` low, a brownout flag causes a brownout-level reset. This asserts power/core and below, but not shutdown memory. With `bor_as_irq_i` high, the flag instead drives `bor_irq_o` high and no reset occurs.
- R9: A rising edge on `shdn_exit_i` causes one brownout-level reset, even if the input stays high. A fatal clock fault causes a boot-level reset.
- R10: While the pin is low, no reset occurs until the long threshold is reached. A press released before `PIN_LONG_TICKS` ticks causes a boot-level reset on release.
- R11: When `PIN_LONG_TICKS` slow ticks have been counted with the pin low, a power-on-level reset starts while the pin is still held. Releasing that same press later causes no further reset.
- R12: A trigger of a higher level during a sequence restarts the sequence from that level. A trigger of a lower or equal level during a sequence is ignored.
- R13: `cause_o` holds the highest level reached since the sequence left run. It uses the codes 5 = power-on, 4 = brownout, 3 = boot, 2 = system and 1 = CPU-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | controller clock |
| por_n_i | input | 1 | supply good, low forces power-on level asynchronously |
| bor_flag_i | input | 1 | brownout detected (asynchronous) |
| bor_as_irq_i | input | 1 | 1: brownout raises interrupt instead of reset |
| shdn_exit_i | input | 1 | shutdown-exit event, rising edge used (asynchronous) |
| ext_rst_n_i | input | 1 | external reset pin, active low (asynchronous) |
| slow_tick_i | input | 1 | one-cycle slow-clock tick for pin timing |
| clk_fault_i | input | 1 | fatal clock failure (asynchronous) |
| sw_req_i | input | 1 | software reset request pulse |
| sw_level_i | input | 3 | software level code |
| wdt_expire_i | input | 1 | watchdog expiry pulse |
| bsl_evt_i | input | 1 | boot-loader entry/exit pulse |
| dbg_req_i | input | 1 | debug reset request pulse |
| dbg_cpu_only_i | input | 1 | 1: debug request is CPU-only, 0: system |
| boot_done_i | input | 1 | boot routine finished |
| shmem_rst_o | output | 1 | shutdown-retention memory reset |
| pwr_rst_o | output | 1 | power-management / core-supply reset |
| rtc_rst_o | output | 1 | RTC and low-frequency clock domain reset |
| periph_rst_o | output | 1 | peripheral reset |
| cpu_rst_o | output | 1 | CPU reset |
| boot_start_o | output | 1 | boot routine start pulse |
| run_o | output | 1 | all resets released |
| bor_irq_o | output | 1 | brownout interrupt |
| cause_o | output | 3 | highest level of the last sequence |

## Verification
The hardest situations to reach are those where two things overlap in time. One is a higher trigger landing while a weaker level is still counting out its hold. The other is a lower trigger arriving in the same window and having to be discarded.

The bench reaches these from the ports by issuing synchronous requests only a few cycles apart. For example, it sends a watchdog pulse followed two cycles later by a power-on code, or a system code followed by a CPU-only code. It then counts, cycle by cycle, how long each decoded level was visible.

The long pin press is reached by holding the pin low across the scaled tick threshold. The boot handshake is held open by switching off the automatic responder.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic [2:0] {
        LV_RUN  = 3'd0,
        LV_CPU  = 3'd1,
        LV_SYS  = 3'd2,
        LV_BOOT = 3'd3,
        LV_BOR  = 3'd4,
        LV_POR  = 3'd5
    } lvl_e;

    function automatic lvl_e lvl_max(input lvl_e a, input lvl_e b);
        return (a > b) ? a : b;
    endfunction

    // software code to level, invalid codes map to run (no request)
    function automatic lvl_e sw_code_lvl(input logic [2:0] code);
        case (code)
            3'd5:    return LV_POR;
            3'd3:    return LV_BOOT;
            3'd2:    return LV_SYS;
            3'd1:    return LV_CPU;
            default: return LV_RUN;
        endcase
    endfunction

endpackage

// File: rtl/rcc_sync.sv
module rcc_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk_i,
    input  logic         rst_n_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < STAGES; i++) begin
                stg_q[i] <= stg_d[i];
            end
        end
    end

    assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/rcc_pin_timer.sv
module rcc_pin_timer #(
    parameter int PIN_LONG_TICKS = 32768
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic pin_low_i,
    input  logic tick_i,
    output logic short_o,
    output logic long_o
);

    localparam int CW = $clog2(PIN_LONG_TICKS + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          was_low;
        logic          fired;
        logic          short_p;
        logic          long_p;
    } pin_st_t;

    pin_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.short_p = 1'b0;
        st_d.long_p  = 1'b0;
        if (pin_low_i) begin
            st_d.was_low = 1'b1;
            if (tick_i && !st_q.fired) begin
                if (st_q.cnt == CW'(PIN_LONG_TICKS - 1)) begin
                    st_d.fired  = 1'b1;
                    st_d.long_p = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
        end else begin
            st_d.short_p = st_q.was_low && !st_q.fired;
            st_d.was_low = 1'b0;
            st_d.fired   = 1'b0;
            st_d.cnt     = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign short_o = st_q.short_p;
    assign long_o  = st_q.long_p;

endmodule

// File: rtl/rcc_seq.sv
module rcc_seq
    import rcc_pkg::*;
#(
    parameter int HOLD_CYC = 16
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  lvl_e req_i,
    input  logic boot_done_i,
    output lvl_e lvl_o,
    output logic boot_go_o,
    output lvl_e cause_o
);

    localparam int CW = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        lvl_e          lvl;
        logic [CW-1:0] cnt;
        logic          boot_wait;
        logic          boot_go;
        lvl_e          cause;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    hold_done;

    assign hold_done = (st_q.cnt == CW'(HOLD_CYC - 1));

    always_comb begin
        st_d         = st_q;
        st_d.boot_go = 1'b0;
        if (req_i > st_q.lvl) begin
            // stronger request: restart the chain from it
            st_d.lvl       = req_i;
            st_d.cnt       = '0;
            st_d.boot_wait = 1'b0;
            st_d.cause     = (st_q.lvl == LV_RUN) ? req_i : lvl_max(st_q.cause, req_i);
        end else if (st_q.lvl != LV_RUN) begin
            if (st_q.boot_wait) begin
                if (boot_done_i) begin
                    st_d.lvl       = LV_SYS;
                    st_d.cnt       = '0;
                    st_d.boot_wait = 1'b0;
                end
            end else if (!hold_done) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end else begin
                st_d.cnt = '0;
                case (st_q.lvl)
                    LV_POR:  st_d.lvl = LV_BOR;
                    LV_BOR:  st_d.lvl = LV_BOOT;
                    LV_BOOT: begin
                        st_d.boot_wait = 1'b1;
                        st_d.boot_go   = 1'b1;
                    end
                    default: st_d.lvl = LV_RUN;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.lvl       <= LV_POR;
            st_q.cnt       <= '0;
            st_q.boot_wait <= 1'b0;
            st_q.boot_go   <= 1'b0;
            st_q.cause     <= LV_POR;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o     = st_q.lvl;
    assign boot_go_o = st_q.boot_go;
    assign cause_o   = st_q.cause;

endmodule

// File: rtl/rst_cascade_ctrl.sv
module rst_cascade_ctrl
    import rcc_pkg::*;
#(
    parameter int HOLD_CYC       = 16,
    parameter int PIN_LONG_TICKS = 32768,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk_i,
    input  logic       por_n_i,
    input  logic       bor_flag_i,
    input  logic       bor_as_irq_i,
    input  logic       shdn_exit_i,
    input  logic       ext_rst_n_i,
    input  logic       slow_tick_i,
    input  logic       clk_fault_i,
    input  logic       sw_req_i,
    input  logic [2:0] sw_level_i,
    input  logic       wdt_expire_i,
    input  logic       bsl_evt_i,
    input  logic       dbg_req_i,
    input  logic       dbg_cpu_only_i,
    input  logic       boot_done_i,
    output logic       shmem_rst_o,
    output logic       pwr_rst_o,
    output logic       rtc_rst_o,
    output logic       periph_rst_o,
    output logic       cpu_rst_o,
    output logic       boot_start_o,
    output logic       run_o,
    output logic       bor_irq_o,
    output logic [2:0] cause_o
);

    localparam int NUM_ASYNC = 4;
    localparam int IX_BOR    = 0;
    localparam int IX_SHDN   = 1;
    localparam int IX_PIN    = 2;
    localparam int IX_CLKF   = 3;
    localparam logic [NUM_ASYNC-1:0] ASYNC_RST = NUM_ASYNC'(1) << IX_PIN;
    localparam int NUM_DOM   = 5;

    typedef struct packed {
        logic [NUM_DOM-1:0] dom;
        logic               run;
        logic               irq;
        logic               shdn_prev;
    } top_st_t;

    logic [NUM_ASYNC-1:0] async_vec, sync_vec;
    logic                 pin_short, pin_long;
    lvl_e                 req_lvl, cur_lvl, cause_lvl;
    logic                 boot_go;
    top_st_t              st_d, st_q;

    assign async_vec[IX_BOR]  = bor_flag_i;
    assign async_vec[IX_SHDN] = shdn_exit_i;
    assign async_vec[IX_PIN]  = ext_rst_n_i;
    assign async_vec[IX_CLKF] = clk_fault_i;

    rcc_sync #(
        .W       (NUM_ASYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (ASYNC_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (por_n_i),
        .async_i (async_vec),
        .sync_o  (sync_vec)
    );

    rcc_pin_timer #(
        .PIN_LONG_TICKS (PIN_LONG_TICKS)
    ) u_pin (
        .clk_i     (clk_i),
        .rst_n_i   (por_n_i),
        .pin_low_i (!sync_vec[IX_PIN]),
        .tick_i    (slow_tick_i),
        .short_o   (pin_short),
        .long_o    (pin_long)
    );

    // merge every trigger into the strongest requested level
    always_comb begin
        req_lvl = LV_RUN;
        if (pin_long) begin
            req_lvl = lvl_max(req_lvl, LV_POR);
        end
        if (sw_req_i) begin
            req_lvl = lvl_max(req_lvl, sw_code_lvl(sw_level_i));
        end
        if (sync_vec[IX_BOR] && !bor_as_irq_i) begin
            req_lvl = lvl_max(req_lvl, LV_BOR);
        end
        if (sync_vec[IX_SHDN] && !st_q.shdn_prev) begin
            req_lvl = lvl_max(req_lvl, LV_BOR);
        end
        if (sync_vec[IX_CLKF] || pin_short) begin
            req_lvl = lvl_max(req_lvl, LV_BOOT);
        end
        if (wdt_expire_i || bsl_evt_i) begin
            req_lvl = lvl_max(req_lvl, LV_SYS);
        end
        if (dbg_req_i) begin
            req_lvl = lvl_max(req_lvl, dbg_cpu_only_i ? LV_CPU : LV_SYS);
        end
    end

    rcc_seq #(
        .HOLD_CYC (HOLD_CYC)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_n_i     (por_n_i),
        .req_i       (req_lvl),
        .boot_done_i (boot_done_i),
        .lvl_o       (cur_lvl),
        .boot_go_o   (boot_go),
        .cause_o     (cause_lvl)
    );

    // registered domain decode keeps the reset lines glitch free
    always_comb begin
        st_d           = st_q;
        st_d.dom[4]    = (cur_lvl == LV_POR);
        st_d.dom[3]    = (cur_lvl >= LV_BOR);
        st_d.dom[2]    = (cur_lvl >= LV_BOOT);
        st_d.dom[1]    = (cur_lvl >= LV_SYS);
        st_d.dom[0]    = (cur_lvl >= LV_CPU);
        st_d.run       = (cur_lvl == LV_RUN);
        st_d.irq       = sync_vec[IX_BOR] && bor_as_irq_i;
        st_d.shdn_prev = sync_vec[IX_SHDN];
    end

    always_ff @(posedge clk_i or negedge por_n_i) begin
        if (!por_n_i) begin
            st_q.dom       <= '1;
            st_q.run       <= 1'b0;
            st_q.irq       <= 1'b0;
            st_q.shdn_prev <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shmem_rst_o  = st_q.dom[4];
    assign pwr_rst_o    = st_q.dom[3];
    assign rtc_rst_o    = st_q.dom[2];
    assign periph_rst_o = st_q.dom[1];
    assign cpu_rst_o    = st_q.dom[0];
    assign run_o        = st_q.run;
    assign bor_irq_o    = st_q.irq;
    assign boot_start_o = boot_go;
    assign cause_o      = cause_lvl;

endmodule

// File: rtl/rcc_checker.sv
module rcc_checker (
    input logic       clk_i,
    input logic       por_n_i,
    input logic       boot_done_i,
    input logic       shmem_rst_o,
    input logic       pwr_rst_o,
    input logic       rtc_rst_o,
    input logic       periph_rst_o,
    input logic       cpu_rst_o,
    input logic       boot_start_o,
    input logic       run_o,
    input logic [2:0] cause_o
);

    AST_NESTED_DOMAINS: assert property (@(posedge clk_i) disable iff (!por_n_i)
        (!shmem_rst_o || pwr_rst_o) && (!pwr_rst_o || rtc_rst_o) &&
        (!rtc_rst_o || periph_rst_o) && (!periph_rst_o || cpu_rst_o)); // R1

    AST_RUN_CLEAR: assert property (@(posedge clk_i) disable iff (!por_n_i)
        run_o |-> !cpu_rst_o); // R1

    AST_BOOT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        boot_start_o |=> !boot_start_o); // R4

    AST_BOOT_IN_BOOT_LEVEL: assert property (@(posedge clk_i) disable iff (!por_n_i)
        boot_start_o |-> (rtc_rst_o && !pwr_rst_o)); // R4

    AST_RTC_WAITS_DONE: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $fell(rtc_rst_o) |-> $past(boot_done_i, 2)); // R4

    AST_CAUSE_VALID: assert property (@(posedge clk_i) disable iff (!por_n_i)
        $rose(run_o) |-> (cause_o != 3'd0 && cause_o <= 3'd5)); // R13

endmodule

bind rst_cascade_ctrl rcc_checker u_rcc_checker (
    .clk_i        (clk_i),
    .por_n_i      (por_n_i),
    .boot_done_i  (boot_done_i),
    .shmem_rst_o  (shmem_rst_o),
    .pwr_rst_o    (pwr_rst_o),
    .rtc_rst_o    (rtc_rst_o),
    .periph_rst_o (periph_rst_o),
    .cpu_rst_o    (cpu_rst_o),
    .boot_start_o (boot_start_o),
    .run_o        (run_o),
    .cause_o      (cause_o)
);

// File: tb/rst_cascade_ctrl_test.sv
module rst_cascade_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 4;
    localparam int LONG       = 8;
    localparam int TICK_DIV   = 4;

    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic       bor_flag = 1'b0, bor_as_irq = 1'b0, shdn_exit = 1'b0;
    logic       ext_rst_n = 1'b1, slow_tick = 1'b0, clk_fault = 1'b0;
    logic       sw_req = 1'b0;
    logic [2:0] sw_level = 3'd0;
    logic       wdt = 1'b0, bsl = 1'b0, dbg_req = 1'b0, dbg_cpu = 1'b0;
    logic       boot_done = 1'b0;
    logic       shmem_rst, pwr_rst, rtc_rst, periph_rst, cpu_rst;
    logic       boot_start, run, bor_irq;
    logic [2:0] cause;

    int total = 0, bad = 0;
    int dur [6];
    int nonrun, mx, boot_cnt, casc_bad;
    logic auto_boot = 1'b1;

    rst_cascade_ctrl #(.HOLD_CYC(H), .PIN_LONG_TICKS(LONG), .SYNC_STAGES(2)) uut (
        .clk_i(clk), .por_n_i(por_n), .bor_flag_i(bor_flag), .bor_as_irq_i(bor_as_irq),
        .shdn_exit_i(shdn_exit), .ext_rst_n_i(ext_rst_n), .slow_tick_i(slow_tick),
        .clk_fault_i(clk_fault), .sw_req_i(sw_req), .sw_level_i(sw_level),
        .wdt_expire_i(wdt), .bsl_evt_i(bsl), .dbg_req_i(dbg_req),
        .dbg_cpu_only_i(dbg_cpu), .boot_done_i(boot_done),
        .shmem_rst_o(shmem_rst), .pwr_rst_o(pwr_rst), .rtc_rst_o(rtc_rst),
        .periph_rst_o(periph_rst), .cpu_rst_o(cpu_rst), .boot_start_o(boot_start),
        .run_o(run), .bor_irq_o(bor_irq), .cause_o(cause)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // slow tick generator
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    end

    // boot routine model
    initial begin
        forever begin
            @(negedge clk);
            if (auto_boot && boot_start) begin
                repeat (3) @(negedge clk);
                boot_done = 1'b1;
                @(negedge clk);
                boot_done = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_ge(input string tag, input int act, input int lim);
        total++;
        if (act < lim) begin
            bad++;
            $display("FAIL %s actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    task automatic clear_mon();
        for (int i = 0; i < 6; i++) dur[i] = 0;
        nonrun = 0; mx = 0; boot_cnt = 0;
    endtask

    task automatic sample_cycle();
        logic [4:0] v;
        int lv;
        @(negedge clk);
        v = {shmem_rst, pwr_rst, rtc_rst, periph_rst, cpu_rst};
        if (!(v inside {5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111, 5'b11111}))
            casc_bad++;
        if (v != 5'b00000 && run) casc_bad++;
        lv = $countones(v);
        if (lv > 0) begin
            dur[lv]++;
            nonrun++;
        end
        if (lv > mx) mx = lv;
        if (boot_start) boot_cnt++;
    endtask

    task automatic sample_n(input int n);
        for (int i = 0; i < n; i++) sample_cycle();
    endtask

    task automatic wait_run(input string tag);
        int guard = 0;
        do begin
            sample_cycle();
            guard++;
        end while (!(run && nonrun > 0) && guard < 2000);
        check({tag, " reached run"}, int'(run && nonrun > 0), 1);
    endtask

    task automatic pulse_sw(input logic [2:0] code);
        sw_level = code;
        sw_req = 1'b1;
        sample_cycle();
        sw_req = 1'b0;
    endtask

    task automatic t_power_on();
        #1 por_n = 1'b0;
        #2;
        check("R2 async all resets", int'({shmem_rst, pwr_rst, rtc_rst, periph_rst, cpu_rst}), 31);
        check("R2 run low in reset", int'(run), 0);
        check("R2 cause in reset", int'(cause), 5);
        repeat (3) @(negedge clk);
        #1 por_n = 1'b1;
        clear_mon();
        wait_run("R2");
        check_ge("R2 power-on level held", dur[5], H - 1);
        check("R3 brownout hold", dur[4], H);
        check_ge("R4 boot waits beyond hold", dur[3], H + 1);
        check("R3 system hold", dur[2], H);
        check("R2 no cpu-only stage", dur[1], 0);
        check("R4 single boot pulse", boot_cnt, 1);
        check("R13 cause power-on", int'(cause), 5);
    endtask

    task automatic t_async_mid_run();
        @(negedge clk);
        #1 por_n = 1'b0;
        #2;
        check("R2 async assert without edge", int'(shmem_rst && cpu_rst && !run), 1);
        @(negedge clk);
        #1 por_n = 1'b1;
        clear_mon();
        wait_run("R2 reassert");
        check("R2 brownout after power-on", dur[4], H);
    endtask

    task automatic t_boot_handshake();
        auto_boot = 1'b0;
        clear_mon();
        pulse_sw(3'd3);
        sample_n(40);
        check("R4 rtc held without done", int'(rtc_rst), 1);
        check("R4 boot pulse once", boot_cnt, 1);
        boot_done = 1'b1;
        sample_cycle();
        boot_done = 1'b0;
        wait_run("R4");
        check("R4 system hold after done", dur[2], H);
        check("R4 no power levels", dur[4] + dur[5], 0);
        check("R13 cause boot", int'(cause), 3);
        auto_boot = 1'b1;
    endtask

    task automatic t_system_sources();
        for (int s = 0; s < 3; s++) begin
            clear_mon();
            if (s == 0) wdt = 1'b1;
            else if (s == 1) bsl = 1'b1;
            else begin dbg_cpu = 1'b0; dbg_req = 1'b1; end
            sample_cycle();
            wdt = 1'b0; bsl = 1'b0; dbg_req = 1'b0;
            wait_run("R5");
            check("R5 max level system", mx, 2);
            check("R5 system hold", dur[2], H);
            check("R13 cause system", int'(cause), 2);
        end
    endtask

    task automatic t_cpu_only();
        clear_mon();
        pulse_sw(3'd1);
        wait_run("R6 sw");
        check("R6 sw cpu-only max", mx, 1);
        check("R6 sw cpu-only hold", dur[1], H);
        clear_mon();
        dbg_cpu = 1'b1; dbg_req = 1'b1;
        sample_cycle();
        dbg_req = 1'b0; dbg_cpu = 1'b0;
        wait_run("R6 dbg");
        check("R6 dbg cpu-only max", mx, 1);
        check("R13 cause cpu", int'(cause), 1);
    endtask

    task automatic t_sw_codes();
        clear_mon();
        pulse_sw(3'd5);
        wait_run("R7 code5");
        check("R7 code 5 power-on", mx, 5);
        check("R3 power-on hold via sw", dur[5], H);
        for (int c = 0; c < 8; c++) begin
            if (c == 0 || c == 4 || c == 6 || c == 7) begin
                clear_mon();
                pulse_sw(3'(c));
                sample_n(20);
                check($sformatf("R7 code %0d ignored", c), nonrun, 0);
            end
        end
    endtask

    task automatic t_brownout();
        bor_as_irq = 1'b0;
        clear_mon();
        bor_flag = 1'b1;
        sample_n(2);
        bor_flag = 1'b0;
        wait_run("R8 reset mode");
        check("R8 max level brownout", mx, 4);
        check("R8 brownout hold", dur[4], H);
        check("R13 cause brownout", int'(cause), 4);
        bor_as_irq = 1'b1;
        clear_mon();
        bor_flag = 1'b1;
        sample_n(5);
        check("R8 irq raised", int'(bor_irq), 1);
        bor_flag = 1'b0;
        sample_n(5);
        check("R8 irq mode no reset", nonrun, 0);
        check("R8 irq cleared", int'(bor_irq), 0);
        bor_as_irq = 1'b0;
    endtask

    task automatic t_shdn_clkfault();
        clear_mon();
        shdn_exit = 1'b1;
        sample_n(12);
        shdn_exit = 1'b0;
        wait_run("R9 shutdown exit");
        check("R9 single brownout from edge", dur[4], H);
        check("R9 shutdown no power-on", dur[5], 0);
        clear_mon();
        clk_fault = 1'b1;
        sample_n(2);
        clk_fault = 1'b0;
        wait_run("R9 clock fault");
        check("R9 clock fault boot level", mx, 3);
    endtask

    task automatic t_pin_short();
        clear_mon();
        ext_rst_n = 1'b0;
        sample_n(12);
        check("R10 no reset while held", nonrun, 0);
        ext_rst_n = 1'b1;
        wait_run("R10");
        check("R10 short press boot level", mx, 3);
        check("R13 cause short press", int'(cause), 3);
    endtask

    task automatic t_pin_long();
        clear_mon();
        ext_rst_n = 1'b0;
        wait_run("R11");
        check("R11 long press power-on", mx, 5);
        check("R11 pin still held", int'(ext_rst_n), 0);
        check("R13 cause long press", int'(cause), 5);
        clear_mon();
        sample_n(20);
        ext_rst_n = 1'b1;
        sample_n(20);
        check("R11 release after long press ignored", nonrun, 0);
    endtask

    task automatic t_preempt();
        clear_mon();
        wdt = 1'b1;
        sample_cycle();
        wdt = 1'b0;
        sample_n(2);
        pulse_sw(3'd5);
        wait_run("R12 higher");
        check("R12 restart at power-on", dur[5], H);
        check("R12 brownout after restart", dur[4], H);
        check("R13 cause after preempt", int'(cause), 5);
        clear_mon();
        pulse_sw(3'd2);
        pulse_sw(3'd1);
        wait_run("R12 lower");
        check("R12 lower request ignored", dur[1], 0);
        check("R12 system hold unchanged", dur[2], H);
        check("R13 cause stays system", int'(cause), 2);
    endtask

    initial begin
        casc_bad = 0;
        clear_mon();
        t_power_on();
        t_async_mid_run();
        t_boot_handshake();
        t_system_sources();
        t_cpu_only();
        t_sw_codes();
        t_brownout();
        t_shdn_clkfault();
        t_pin_short();
        t_pin_long();
        t_preempt();
        check("R1 domains always nested", casc_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule